// File: doc/BRIEF.md
# Cascaded Timer Interrupt Controller

This block derives a chain of slow timing events from a single base tick and gathers four interrupt sources into latches that drive one request line to the CPU. A first down counter divides the base tick to a 1 kHz rate. A second counter, advanced by the first, produces a 50 Hz rate. A third counter, advanced by the second, toggles a slow 1 Hz source level. A sound-timer source level toggles on the underflow of one of four selectable events: the 1 kHz stage, the 50 Hz stage, or an underflow strobe from one of two external tone channels. Two active-low external interrupt pins complete the set of four sources.

Each source has an enable bit and a latch. The sound and 1 Hz latches are set on each toggle of their level. The external latches are set on a falling edge of their pin. A set latch is only affected again by a control write. Enable and clear are written together through one control byte, which is XOR-ed with 0x55 before it is decoded. A status byte reports each source's live level and its latch. The request output is high while any latch is set.

Top module: `tic_ctrl`

## Requirements
- R1: While `tick_i` is high, the first counter counts down from `DIV_1K` to 0. The tick that finds it at 0 is an underflow and reloads `DIV_1K`. Cycles without a tick do not advance it. After reset the counter holds its reload value, so the first underflow happens on tick number `DIV_1K+1`.
- R2: The second counter advances only on first-stage underflows. It has the same count, reload and underflow rules as R1, with reload value `DIV_50`.
- R3: The third counter advances only on second-stage underflows, with reload value `DIV_1HZ`. Each of its underflows inverts the 1 Hz level.
- R4: `snd_sel_i` picks the sound event: 0 is the first-stage underflow, 1 is the second-stage underflow, 2 is `tone0_uf_i` and 3 is `tone1_uf_i`. Each sound event inverts the sound level. An unselected strobe has no effect.
- R5: A sound or 1 Hz event sets that source's latch if its enable is set. A disabled event leaves the latch clear. A set latch stays set until a control write clears it.
- R6: An external latch is set only when its pin goes from high to low while its enable is set. The level bit reports the pin as registered at the previous clock edge.
- R7: A control write applies x = wr_data ^ 0x55. Pair i is bits 2i+1:2i, and the sources are sound (i=0), 1 Hz (i=1), ext1 (i=2) and ext2 (i=3). The source's enable becomes the inverse of x[2i]. Its latch clears when x[2i] or x[2i+1] is 1.
- R8: `rd_data_o` bit 2i is source i's level and bit 2i+1 is source i's latch.
- R9: `irq_o` is registered. It equals the OR of the latches as they stood one cycle earlier. It therefore drops only on the second cycle after a write that cleared the last set latch.
- R10: After reset all enables are off, all latches are clear, the sound and 1 Hz levels are 0, both external levels are 1, `rd_data_o` is 0x50 and `irq_o` is 0.
- R11: If a control write clears a latch in the same cycle as that latch's set event, the latch ends clear. The set decision uses the enable that was in force before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Single-cycle base-rate strobe |
| snd_sel_i | input | 2 | Sound event select |
| tone0_uf_i | input | 1 | Tone channel 0 underflow strobe |
| tone1_uf_i | input | 1 | Tone channel 1 underflow strobe |
| ext1_n_i | input | 1 | External interrupt 1, active low |
| ext2_n_i | input | 1 | External interrupt 2, active low |
| wr_en_i | input | 1 | Control byte write strobe |
| wr_data_i | input | 8 | Control byte |
| rd_data_o | output | 8 | Status byte |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
On every cycle, the assertions check several invariants. No counter leaves its range, and each underflow reloads it. A latch rises only on an enabled event of its own source. A clearing write always leaves the latch low on the next cycle. The 1 Hz level changes only on a third-stage underflow. The request line rises only after a set latch and falls only after a write.

The bench scenarios cover behaviour that no per-cycle property states. These include the exact divide ratios over long runs and the routing of each sound-select value. They also cover the XOR decoding of enable and clear from real byte values, and the status bit layout. Finally they cover the same-cycle race between a clearing write and a set event.

// File: rtl/tic_pkg.sv
package tic_pkg;
    localparam int          NSRC     = 4;
    localparam int          NSTAGE   = 3;
    localparam logic [7:0]  CTRL_XOR = 8'h55;

    typedef enum logic [1:0] {
        SND_FROM_1K    = 2'd0,
        SND_FROM_50    = 2'd1,
        SND_FROM_TONE0 = 2'd2,
        SND_FROM_TONE1 = 2'd3
    } snd_sel_e;

    typedef struct packed {
        logic lvl_snd;
        logic lvl_slow;
        logic ext1_q;
        logic ext2_q;
        logic irq;
    } top_state_t;
endpackage

// File: rtl/tic_stage.sv
module tic_stage #(
    parameter int RELOAD = 249
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    output logic uf_o
);
    localparam int W = (RELOAD < 1) ? 1 : $clog2(RELOAD + 1);
    localparam logic [W-1:0] RLD = W'(RELOAD);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        uf_o  = step_i && (cnt_q == '0);
        cnt_d = cnt_q;
        if (step_i) begin
            cnt_d = (cnt_q == '0) ? RLD : cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= RLD;
        else        cnt_q <= cnt_d;
    end

    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= RLD);
    assert_uf_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        uf_o |=> (cnt_q == RLD));
    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(cnt_q));
endmodule

// File: rtl/tic_latch.sv
module tic_latch (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_ev_i,
    input  logic       wr_en_i,
    input  logic [1:0] pair_i,
    output logic       lat_o
);
    logic en_d, en_q, lat_d, lat_q;

    always_comb begin
        en_d  = en_q;
        lat_d = lat_q;
        if (set_ev_i && en_q) lat_d = 1'b1;
        if (wr_en_i) begin
            en_d = ~pair_i[0];
            if (|pair_i) lat_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            lat_q <= 1'b0;
        end else begin
            en_q  <= en_d;
            lat_q <= lat_d;
        end
    end

    assign lat_o = lat_q;

    assert_set_needs_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lat_q) |-> $past(set_ev_i && en_q));
    assert_wr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (|pair_i)) |=> !lat_q);
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q && !wr_en_i) |=> lat_q);
endmodule

// File: rtl/tic_ctrl.sv
module tic_ctrl
    import tic_pkg::*;
#(
    parameter int DIV_1K  = 249,
    parameter int DIV_50  = 19,
    parameter int DIV_1HZ = 49
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic [1:0] snd_sel_i,
    input  logic       tone0_uf_i,
    input  logic       tone1_uf_i,
    input  logic       ext1_n_i,
    input  logic       ext2_n_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] rd_data_o,
    output logic       irq_o
);
    localparam int RELOADS [NSTAGE] = '{DIV_1K, DIV_50, DIV_1HZ};

    logic [NSTAGE:0]   step;
    logic [NSTAGE-1:0] uf;
    logic [NSRC-1:0]   set_ev;
    logic [NSRC-1:0]   lat;
    logic [7:0]        wr_x;
    logic              snd_ev;
    top_state_t        st_d, st_q;

    assign step[0] = tick_i;

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        tic_stage #(.RELOAD(RELOADS[g])) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .step_i (step[g]),
            .uf_o   (uf[g])
        );
        assign step[g+1] = uf[g];
    end

    always_comb begin
        unique case (snd_sel_e'(snd_sel_i))
            SND_FROM_1K:    snd_ev = uf[0];
            SND_FROM_50:    snd_ev = uf[1];
            SND_FROM_TONE0: snd_ev = tone0_uf_i;
            default:        snd_ev = tone1_uf_i;
        endcase
    end

    assign wr_x   = wr_data_i ^ CTRL_XOR;
    assign set_ev = {st_q.ext2_q & ~ext2_n_i,
                     st_q.ext1_q & ~ext1_n_i,
                     uf[NSTAGE-1],
                     snd_ev};

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        tic_latch u_latch (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_ev_i (set_ev[s]),
            .wr_en_i  (wr_en_i),
            .pair_i   (wr_x[2*s+1 -: 2]),
            .lat_o    (lat[s])
        );
    end

    always_comb begin
        st_d          = st_q;
        st_d.lvl_snd  = st_q.lvl_snd  ^ snd_ev;
        st_d.lvl_slow = st_q.lvl_slow ^ uf[NSTAGE-1];
        st_d.ext1_q   = ext1_n_i;
        st_d.ext2_q   = ext2_n_i;
        st_d.irq      = |lat;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{lvl_snd: 1'b0, lvl_slow: 1'b0, ext1_q: 1'b1,
                      ext2_q: 1'b1, irq: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = {lat[3], st_q.ext2_q, lat[2], st_q.ext1_q,
                        lat[1], st_q.lvl_slow, lat[0], st_q.lvl_snd};
    assign irq_o     = st_q.irq;

    assert_slow_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lvl_slow != $past(st_q.lvl_slow)) |-> $past(uf[NSTAGE-1]));
    assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(|lat));
    assert_irq_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(wr_en_i, 2));
    assert_stage_chain_R2: assert property (@(posedge clk) disable iff (!rst_n)
        uf[1] |-> uf[0]);
endmodule

// File: tb/sim_tic_ctrl.sv
module sim_tic_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int P1K = 4;
    localparam int P50 = 2;
    localparam int P1  = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       t0 = 1'b0, t1 = 1'b0;
    logic       e1 = 1'b1, e2 = 1'b1;
    logic       wr = 1'b0;
    logic [7:0] wd = 8'h00;
    logic [7:0] rd;
    logic       irq;

    int total = 0, bad = 0, cycles = 0;
    string tag = "R10";

    int m_c[3];
    bit m_ls, m_l1, m_e1, m_e2, m_irq;
    bit m_en[4], m_lat[4];

    always #(CLK_PERIOD/2) clk = ~clk;

    tic_ctrl #(.DIV_1K(P1K), .DIV_50(P50), .DIV_1HZ(P1)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .snd_sel_i(sel),
        .tone0_uf_i(t0), .tone1_uf_i(t1), .ext1_n_i(e1), .ext2_n_i(e2),
        .wr_en_i(wr), .wr_data_i(wd), .rd_data_o(rd), .irq_o(irq));

    function automatic void model_reset();
        m_c[0] = P1K; m_c[1] = P50; m_c[2] = P1;
        m_ls = 0; m_l1 = 0; m_e1 = 1; m_e2 = 1; m_irq = 0;
        for (int i = 0; i < 4; i++) begin m_en[i] = 0; m_lat[i] = 0; end
    endfunction

    function automatic int reload_of(int k);
        return (k == 0) ? P1K : (k == 1) ? P50 : P1;
    endfunction

    function automatic void model_step();
        bit uf[3];
        bit step, sev;
        bit ev[4];
        bit [7:0] x;
        bit any;
        step = tick;
        for (int k = 0; k < 3; k++) begin
            uf[k] = step && (m_c[k] == 0);
            if (step) m_c[k] = (m_c[k] == 0) ? reload_of(k) : m_c[k] - 1;
            step = uf[k];
        end
        case (sel)
            2'd0: sev = uf[0];
            2'd1: sev = uf[1];
            2'd2: sev = t0;
            default: sev = t1;
        endcase
        ev[0] = sev; ev[1] = uf[2];
        ev[2] = m_e1 && !e1; ev[3] = m_e2 && !e2;
        any = 0;
        for (int i = 0; i < 4; i++) any |= m_lat[i];
        m_irq = any;
        x = wd ^ 8'h55;
        for (int i = 0; i < 4; i++) begin
            if (ev[i] && m_en[i]) m_lat[i] = 1;
            if (wr) begin
                if (x[2*i] || x[2*i+1]) m_lat[i] = 0;
                m_en[i] = !x[2*i];
            end
        end
        m_ls ^= sev; m_l1 ^= uf[2]; m_e1 = e1; m_e2 = e2;
    endfunction

    function automatic logic [7:0] exp_rd();
        return {m_lat[3], m_e2, m_lat[2], m_e1, m_lat[1], m_l1, m_lat[0], m_ls};
    endfunction

    task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        if (rst_n) model_step();
        #1;
        cycles++;
        check("status", rd, exp_rd());
        check("irq", {7'd0, irq}, {7'd0, m_irq});
    endtask

    task automatic write(input logic [7:0] v);
        wr = 1; wd = v; cyc(); wr = 0; wd = 8'h00;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin tick = 1; cyc(); end
        tick = 0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (cycles > 150000) begin
                bad++; total++;
                $display("FAIL watchdog expired");
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        #1; rst_n = 1;
        tag = "R10";
        check("reset status", rd, 8'h50);
        check("reset irq", {7'd0, irq}, 8'h00);
        cyc();

        tag = "R1"; sel = 2'd0;
        ticks(4); cyc(); cyc();
        check("no toggle before tick 5", {7'd0, rd[0]}, 8'h00);
        ticks(1);
        check("toggle on tick 5", {7'd0, rd[0]}, 8'h01);
        for (int i = 0; i < 20; i++) begin tick = i[0]; cyc(); end
        tick = 0;

        tag = "R2"; sel = 2'd1; ticks(60);
        tag = "R3"; sel = 2'd0; ticks(200);

        tag = "R4";
        sel = 2'd2; t0 = 1; cyc(); t0 = 0; t1 = 1; cyc(); t1 = 0; cyc();
        sel = 2'd3; t1 = 1; cyc(); t1 = 0; t0 = 1; cyc(); t0 = 0; cyc();

        tag = "R5";
        sel = 2'd2; t0 = 1; cyc(); t0 = 0;
        check("disabled event", {7'd0, rd[1]}, 8'h00);
        tag = "R7"; write(8'h55);
        tag = "R5"; t0 = 1; cyc(); t0 = 0; cyc();
        check("latch set", {7'd0, rd[1]}, 8'h01);
        ticks(60);
        tag = "R9"; cyc();
        check("irq high", {7'd0, irq}, 8'h01);

        tag = "R7"; write(8'hFF); cyc();
        tag = "R9"; cyc();
        tag = "R7"; write(8'h57);
        tag = "R11"; t0 = 1; wr = 1; wd = 8'h57; cyc(); wr = 0; t0 = 0; cyc();
        check("clear wins", {7'd0, rd[1]}, 8'h00);

        tag = "R6";
        write(8'h55);
        e1 = 0; cyc(); cyc(); e1 = 1; cyc(); cyc();
        e2 = 0; cyc(); e2 = 1; cyc();
        check("ext latches", {6'd0, rd[7], rd[5]}, 8'h03);
        write(8'h0F);
        e1 = 0; cyc(); e1 = 1; cyc();
        check("ext disabled", {7'd0, rd[5]}, 8'h00);

        tag = "R8";
        for (int i = 0; i < 4000; i++) begin
            tick = ($urandom % 3) != 0;
            t0 = ($urandom % 7) == 0;
            t1 = ($urandom % 7) == 0;
            if (($urandom % 50) == 0) sel = 2'($urandom);
            if (($urandom % 9) == 0) e1 = ~e1;
            if (($urandom % 11) == 0) e2 = ~e2;
            wr = ($urandom % 25) == 0;
            wd = wr ? 8'($urandom) : 8'h00;
            tag = ((i % 2) == 0) ? "R8" : "R9";
            cyc();
        end
        wr = 0; tick = 0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule